// File: doc/BRIEF.md
# Speculative Reorder Buffer

This block keeps issued instructions in a circular queue in program order until they can retire. When an instruction issues, the block takes the entry at the tail and hands its index back as the result tag. Functional units later place a tagged result on the shared result bus. The block stores that value in the matching entry, together with an exception flag and a branch-mispredict flag, and marks the entry ready. Consumers that are still waiting on a result can look a tag up and receive its value once the entry is ready. Until retirement, the value is visible only through that lookup.

Retirement takes place only at the oldest entry, and only once that entry is ready. A register-producing instruction drives a register write. A store drives a store commit carrying its address and data. A branch that was predicted correctly leaves with no side effect. If the head entry holds an exception or a mispredicted branch, it retires with a flush indication and every entry is discarded in the next cycle. Exceptions are therefore precise, and wrong-path work never becomes visible.

Top module: `rob_core`

## Requirements
- R1: After reset the buffer is empty: occupancy is 0, `empty` is 1, `full` is 0, and none of the retire strobes is asserted.
- R2: An accepted issue writes the entry at the tail index, returns that index on `iss_tag` and raises occupancy by one. When occupancy equals the depth (8), `full` is 1, `iss_ready` is 0 and an issue request is ignored.
- R3: A writeback whose tag names a live entry stores the value, the exception flag and the mispredict flag, and marks the entry ready. A writeback to a tag with no live entry changes nothing.
- R4: `lk_hit` is 1 exactly when the looked-up tag names a live, ready entry. In that case `lk_value` carries that entry's stored value.
- R5: Only the head entry may retire, and it retires in the same cycle in which it is live and ready. The retire outputs are valid in that cycle, `ret_tag` gives the head index, and the head advances on the following edge. Class codes: 2'b00 register op, 2'b01 store, 2'b10 branch.
- R6: When a register op without an exception retires, `ret_reg_we` pulses with its destination register and value. When a store without an exception retires, `ret_store_we` pulses with the store address on `ret_dest` and the store data on `ret_value`.
- R7: A branch retired without a mispredict asserts no register write, no store commit and no flush.
- R8: A mispredicted branch at the head asserts `ret_flush`. On the next edge every entry is discarded, occupancy becomes 0, and the head and tail both return to index 0.
- R9: An exception is only recorded at writeback. It is signalled on `ret_exc` when its entry retires at the head, with no register write or store commit, and it flushes the buffer in the same way as R8.
- R10: In a cycle where a flush is asserted, `iss_ready` is 0 and any issue request is dropped.
- R11: An issue and a retirement in the same cycle leave occupancy unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | Issue request |
| iss_class | input | 2 | Instruction class of the issuing instruction |
| iss_dest | input | 16 | Destination register number, or store address |
| iss_ready | output | 1 | Issue is accepted in this cycle |
| iss_tag | output | 3 | Tag (tail index) given to the issuing instruction |
| wb_valid | input | 1 | Result bus carries a result |
| wb_tag | input | 3 | Tag of the result |
| wb_value | input | 32 | Result value, or store data |
| wb_exc | input | 1 | The instruction raised an exception |
| wb_mispred | input | 1 | The branch was mispredicted |
| lk_tag | input | 3 | Tag to look up |
| lk_hit | output | 1 | The looked-up entry is live and ready |
| lk_value | output | 32 | Value of the looked-up entry |
| ret_reg_we | output | 1 | Register write from the retiring entry |
| ret_store_we | output | 1 | Store commit from the retiring entry |
| ret_exc | output | 1 | The retiring entry raises its exception |
| ret_flush | output | 1 | The buffer is flushed at this retirement |
| ret_dest | output | 16 | Destination of the retiring entry |
| ret_value | output | 32 | Value of the retiring entry |
| ret_tag | output | 3 | Index of the retiring entry |
| occupancy | output | 4 | Number of live entries |
| full | output | 1 | Every entry is in use |
| empty | output | 1 | No entry is in use |

## Verification
Retirement at the head can coincide with an issue at the tail. It can also coincide with a flush while an issue is being requested. The random stream keeps issue requests frequent and lets writebacks complete the head often, so both pairings occur many times. Directed cases add a full buffer that retires while another issue waits, and a mispredicted branch that reaches the head while `iss_valid` is held high. In every cycle a bench model predicts the acceptance, the occupancy, the tail tag and the state after the flush, and compares them with the outputs.

// File: rtl/rob_pkg.sv
package rob_pkg;
    typedef enum logic [1:0] {
        CLS_REG    = 2'b00,
        CLS_STORE  = 2'b01,
        CLS_BRANCH = 2'b10
    } rob_cls_e;
endpackage

// File: rtl/rob_ptrs.sv
module rob_ptrs #(
    parameter int DEPTH = 8,
    parameter int TAG_W = $clog2(DEPTH),
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             do_issue,
    input  logic             do_retire,
    input  logic             do_flush,
    output logic [TAG_W-1:0] head,
    output logic [TAG_W-1:0] tail,
    output logic [CNT_W-1:0] count,
    output logic             full,
    output logic             empty
);
    typedef struct packed {
        logic [TAG_W-1:0] head;
        logic [TAG_W-1:0] tail;
        logic [CNT_W-1:0] count;
    } ptr_s;

    ptr_s ptr_d, ptr_q;

    function automatic logic [TAG_W-1:0] step_ptr(input logic [TAG_W-1:0] p);
        return (p == TAG_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        ptr_d = ptr_q;
        if (do_flush) begin
            ptr_d = '0;
        end else begin
            if (do_retire) ptr_d.head = step_ptr(ptr_q.head);
            if (do_issue)  ptr_d.tail = step_ptr(ptr_q.tail);
            case ({do_issue, do_retire})
                2'b10:   ptr_d.count = ptr_q.count + 1'b1;
                2'b01:   ptr_d.count = ptr_q.count - 1'b1;
                default: ptr_d.count = ptr_q.count;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    assign head  = ptr_q.head;
    assign tail  = ptr_q.tail;
    assign count = ptr_q.count;
    assign full  = (ptr_q.count == CNT_W'(DEPTH));
    assign empty = (ptr_q.count == '0);

    // R2
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH));
    // R2
    issue_not_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        do_issue |-> !full);
    // R5
    retire_not_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        do_retire |-> !empty);
    // R8
    flush_resets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        do_flush |=> (empty && head == '0 && tail == '0));
endmodule

// File: rtl/rob_store.sv
module rob_store #(
    parameter int DEPTH  = 8,
    parameter int TAG_W  = $clog2(DEPTH),
    parameter int DATA_W = 32,
    parameter int DEST_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              alloc_en,
    input  logic [TAG_W-1:0]  alloc_tag,
    input  logic [1:0]        alloc_cls,
    input  logic [DEST_W-1:0] alloc_dest,
    input  logic              wb_en,
    input  logic [TAG_W-1:0]  wb_tag,
    input  logic [DATA_W-1:0] wb_value,
    input  logic              wb_exc,
    input  logic              wb_mispred,
    input  logic              free_en,
    input  logic [TAG_W-1:0]  head_tag,
    input  logic [TAG_W-1:0]  lk_tag,
    output logic              lk_hit,
    output logic [DATA_W-1:0] lk_value,
    output logic              head_live,
    output logic [1:0]        head_cls,
    output logic [DEST_W-1:0] head_dest,
    output logic [DATA_W-1:0] head_value,
    output logic              head_exc,
    output logic              head_mispred
);
    typedef struct packed {
        logic              valid;
        logic              ready;
        logic [1:0]        cls;
        logic [DEST_W-1:0] dest;
        logic [DATA_W-1:0] value;
        logic              exc;
        logic              mispred;
    } ent_s;

    ent_s ent_q [DEPTH];

    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_ent
        localparam logic [TAG_W-1:0] IDX = TAG_W'(gi);
        ent_s e_d, e_q;

        always_comb begin
            e_d = e_q;
            if (flush) begin
                e_d.valid = 1'b0;
            end else begin
                if (free_en && head_tag == IDX) e_d.valid = 1'b0;
                if (alloc_en && alloc_tag == IDX) begin
                    e_d.valid   = 1'b1;
                    e_d.ready   = 1'b0;
                    e_d.cls     = alloc_cls;
                    e_d.dest    = alloc_dest;
                    e_d.value   = '0;
                    e_d.exc     = 1'b0;
                    e_d.mispred = 1'b0;
                end
                if (wb_en && wb_tag == IDX && e_q.valid) begin
                    e_d.ready   = 1'b1;
                    e_d.value   = wb_value;
                    e_d.exc     = wb_exc;
                    e_d.mispred = wb_mispred;
                end
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) e_q <= '0;
            else        e_q <= e_d;
        end

        assign ent_q[gi] = e_q;

        // R3
        wb_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wb_en && wb_tag == IDX && e_q.valid && !flush && !(free_en && head_tag == IDX))
            |=> (e_q.ready && e_q.value == $past(wb_value)));
        // R2
        alloc_fresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (alloc_en && alloc_tag == IDX && !flush) |=> (e_q.valid && !e_q.ready));
        // R8
        flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            flush |=> !e_q.valid);
    end

    assign lk_hit       = ent_q[lk_tag].valid & ent_q[lk_tag].ready;
    assign lk_value     = ent_q[lk_tag].value;
    assign head_live    = ent_q[head_tag].valid & ent_q[head_tag].ready;
    assign head_cls     = ent_q[head_tag].cls;
    assign head_dest    = ent_q[head_tag].dest;
    assign head_value   = ent_q[head_tag].value;
    assign head_exc     = ent_q[head_tag].exc;
    assign head_mispred = ent_q[head_tag].mispred;
endmodule

// File: rtl/rob_core.sv
module rob_core #(
    parameter int DEPTH  = 8,
    parameter int DATA_W = 32,
    parameter int DEST_W = 16,
    localparam int TAG_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              iss_valid,
    input  logic [1:0]        iss_class,
    input  logic [DEST_W-1:0] iss_dest,
    output logic              iss_ready,
    output logic [TAG_W-1:0]  iss_tag,
    input  logic              wb_valid,
    input  logic [TAG_W-1:0]  wb_tag,
    input  logic [DATA_W-1:0] wb_value,
    input  logic              wb_exc,
    input  logic              wb_mispred,
    input  logic [TAG_W-1:0]  lk_tag,
    output logic              lk_hit,
    output logic [DATA_W-1:0] lk_value,
    output logic              ret_reg_we,
    output logic              ret_store_we,
    output logic              ret_exc,
    output logic              ret_flush,
    output logic [DEST_W-1:0] ret_dest,
    output logic [DATA_W-1:0] ret_value,
    output logic [TAG_W-1:0]  ret_tag,
    output logic [CNT_W-1:0]  occupancy,
    output logic              full,
    output logic              empty
);
    import rob_pkg::*;

    logic [TAG_W-1:0] head, tail;
    logic             head_live, head_exc, head_mispred;
    logic [1:0]       head_cls;
    logic             flush_now, accept, wb_en;

    assign flush_now = head_live & (head_exc | (head_cls == CLS_BRANCH && head_mispred));
    assign iss_ready = !full & !flush_now;
    assign accept    = iss_valid & iss_ready;
    assign wb_en     = wb_valid & !flush_now;

    rob_ptrs #(.DEPTH(DEPTH), .TAG_W(TAG_W), .CNT_W(CNT_W)) u_ptrs (
        .clk       (clk),
        .rst_n     (rst_n),
        .do_issue  (accept),
        .do_retire (head_live),
        .do_flush  (flush_now),
        .head      (head),
        .tail      (tail),
        .count     (occupancy),
        .full      (full),
        .empty     (empty)
    );

    rob_store #(.DEPTH(DEPTH), .TAG_W(TAG_W), .DATA_W(DATA_W), .DEST_W(DEST_W)) u_store (
        .clk          (clk),
        .rst_n        (rst_n),
        .flush        (flush_now),
        .alloc_en     (accept),
        .alloc_tag    (tail),
        .alloc_cls    (iss_class),
        .alloc_dest   (iss_dest),
        .wb_en        (wb_en),
        .wb_tag       (wb_tag),
        .wb_value     (wb_value),
        .wb_exc       (wb_exc),
        .wb_mispred   (wb_mispred),
        .free_en      (head_live),
        .head_tag     (head),
        .lk_tag       (lk_tag),
        .lk_hit       (lk_hit),
        .lk_value     (lk_value),
        .head_live    (head_live),
        .head_cls     (head_cls),
        .head_dest    (ret_dest),
        .head_value   (ret_value),
        .head_exc     (head_exc),
        .head_mispred (head_mispred)
    );

    assign iss_tag      = tail;
    assign ret_tag      = head;
    assign ret_exc      = head_live & head_exc;
    assign ret_flush    = flush_now;
    assign ret_reg_we   = head_live & !head_exc & (head_cls == CLS_REG);
    assign ret_store_we = head_live & !head_exc & (head_cls == CLS_STORE);

    // R6
    ret_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ret_reg_we, ret_store_we, ret_flush}));
    // R9
    exc_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ret_exc |-> (ret_flush && !ret_reg_we && !ret_store_we));
    // R10
    flush_blocks_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ret_flush |-> !iss_ready);
    // R11
    swap_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && iss_ready && (ret_reg_we || ret_store_we)) |=> $stable(occupancy));
    // R5
    head_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_reg_we || ret_store_we) |=> (ret_tag != $past(ret_tag) || empty));
endmodule

// File: tb/tb_rob_core.sv
module tb_rob_core;
    localparam int DEPTH = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        iss_valid = 1'b0;
    logic [1:0]  iss_class = 2'b00;
    logic [15:0] iss_dest = '0;
    logic        iss_ready;
    logic [2:0]  iss_tag;
    logic        wb_valid = 1'b0;
    logic [2:0]  wb_tag = '0;
    logic [31:0] wb_value = '0;
    logic        wb_exc = 1'b0;
    logic        wb_mispred = 1'b0;
    logic [2:0]  lk_tag = '0;
    logic        lk_hit;
    logic [31:0] lk_value;
    logic        ret_reg_we, ret_store_we, ret_exc, ret_flush;
    logic [15:0] ret_dest;
    logic [31:0] ret_value;
    logic [2:0]  ret_tag;
    logic [3:0]  occupancy;
    logic        full, empty;

    int total = 0;
    int bad = 0;
    bit done = 0;

    bit          mv [DEPTH];
    bit          mr [DEPTH];
    logic [1:0]  mc [DEPTH];
    logic [15:0] md [DEPTH];
    logic [31:0] mval [DEPTH];
    bit          mx [DEPTH];
    bit          mm [DEPTH];
    int mh = 0, mt = 0, mn = 0;

    always #5 clk = ~clk;

    rob_core dut (
        .clk(clk), .rst_n(rst_n),
        .iss_valid(iss_valid), .iss_class(iss_class), .iss_dest(iss_dest),
        .iss_ready(iss_ready), .iss_tag(iss_tag),
        .wb_valid(wb_valid), .wb_tag(wb_tag), .wb_value(wb_value),
        .wb_exc(wb_exc), .wb_mispred(wb_mispred),
        .lk_tag(lk_tag), .lk_hit(lk_hit), .lk_value(lk_value),
        .ret_reg_we(ret_reg_we), .ret_store_we(ret_store_we), .ret_exc(ret_exc),
        .ret_flush(ret_flush), .ret_dest(ret_dest), .ret_value(ret_value),
        .ret_tag(ret_tag), .occupancy(occupancy), .full(full), .empty(empty)
    );

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
        end
    endtask

    function automatic bit exp_live();
        return mv[mh] && mr[mh];
    endfunction

    function automatic bit exp_flush();
        return exp_live() && (mx[mh] || (mc[mh] == 2'b10 && mm[mh]));
    endfunction

    task automatic idle_inputs();
        iss_valid = 0; iss_class = 0; iss_dest = 0;
        wb_valid = 0; wb_tag = 0; wb_value = 0; wb_exc = 0; wb_mispred = 0;
    endtask

    // Inputs are set at a negedge; compare, take the edge, update the model.
    task automatic step();
        bit hl, fl, rdy, acc;
        #1;
        hl  = exp_live();
        fl  = exp_flush();
        rdy = (mn != DEPTH) && !fl;
        acc = iss_valid && rdy;
        check(fl ? "R10" : "R2", "iss_ready", 32'(iss_ready), 32'(rdy));
        check("R2", "iss_tag", 32'(iss_tag), 32'(mt));
        check("R2", "full", 32'(full), 32'(mn == DEPTH));
        check("R11", "occupancy", 32'(occupancy), 32'(mn));
        check("R1", "empty", 32'(empty), 32'(mn == 0));
        check("R6", "ret_reg_we", 32'(ret_reg_we), 32'(hl && !mx[mh] && mc[mh] == 2'b00));
        check("R6", "ret_store_we", 32'(ret_store_we), 32'(hl && !mx[mh] && mc[mh] == 2'b01));
        check("R9", "ret_exc", 32'(ret_exc), 32'(hl && mx[mh]));
        check("R8", "ret_flush", 32'(ret_flush), 32'(fl));
        if (hl) begin
            check("R5", "ret_tag", 32'(ret_tag), 32'(mh));
            if (mc[mh] == 2'b10 && !mm[mh] && !mx[mh])
                check("R7", "branch_silent", 32'({ret_reg_we, ret_store_we, ret_flush}), 32'd0);
            if (!mx[mh] && mc[mh] != 2'b10) begin
                check("R6", "ret_dest", 32'(ret_dest), 32'(md[mh]));
                check("R6", "ret_value", ret_value, mval[mh]);
            end
        end
        check("R4", "lk_hit", 32'(lk_hit), 32'(mv[lk_tag] && mr[lk_tag]));
        if (mv[lk_tag] && mr[lk_tag]) check("R3", "lk_value", lk_value, mval[lk_tag]);
        @(posedge clk);
        if (fl) begin
            for (int i = 0; i < DEPTH; i++) mv[i] = 0;
            mh = 0; mt = 0; mn = 0;
        end else begin
            if (wb_valid && mv[wb_tag]) begin
                mr[wb_tag] = 1; mval[wb_tag] = wb_value;
                mx[wb_tag] = wb_exc; mm[wb_tag] = wb_mispred;
            end
            if (hl) begin mv[mh] = 0; mh = (mh + 1) % DEPTH; end
            if (acc) begin
                mv[mt] = 1; mr[mt] = 0; mc[mt] = iss_class; md[mt] = iss_dest;
                mval[mt] = 0; mx[mt] = 0; mm[mt] = 0;
                mt = (mt + 1) % DEPTH;
            end
            mn = mn + int'(acc) - int'(hl);
        end
        @(negedge clk);
    endtask

    task automatic rand_cycle();
        int cand [DEPTH];
        int nc = 0;
        idle_inputs();
        for (int i = 0; i < DEPTH; i++) if (mv[i] && !mr[i]) begin cand[nc] = i; nc++; end
        iss_valid  = ($urandom % 100) < 55;
        iss_class  = 2'($urandom % 3);
        iss_dest   = 16'($urandom);
        wb_valid   = ($urandom % 100) < 60;
        if (nc > 0 && ($urandom % 4) != 0) wb_tag = 3'(cand[$urandom % nc]);
        else wb_tag = 3'($urandom);
        wb_value   = $urandom;
        wb_exc     = ($urandom % 25) == 0;
        wb_mispred = ($urandom % 8) == 0;
        lk_tag     = 3'($urandom);
        step();
    endtask

    initial begin
        #2000000;
        if (!done) begin
            total++; bad++;
            $display("FAIL R1 watchdog act=running exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        for (int i = 0; i < DEPTH; i++) begin
            mv[i] = 0; mr[i] = 0; mc[i] = 0; md[i] = 0; mval[i] = 0; mx[i] = 0; mm[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        // R1 reset state
        check("R1", "occupancy", 32'(occupancy), 32'd0);
        check("R1", "empty", 32'(empty), 32'd1);
        check("R1", "full", 32'(full), 32'd0);
        check("R1", "strobes", 32'({ret_reg_we, ret_store_we, ret_exc, ret_flush}), 32'd0);
        @(negedge clk);

        // R2 fill to full, then an extra request is refused
        for (int i = 0; i < DEPTH; i++) begin
            idle_inputs(); iss_valid = 1; iss_class = 2'(i % 2); iss_dest = 16'(16'h100 + i);
            step();
        end
        idle_inputs(); iss_valid = 1; iss_dest = 16'hdead;
        step();
        #1 check("R2", "full_held", 32'(occupancy), 32'd8);

        // R5 a ready non-head entry does not retire; lookup sees it
        idle_inputs(); wb_valid = 1; wb_tag = 3; wb_value = 32'h3333_0003; lk_tag = 3;
        step();
        #1 check("R5", "no_early_retire", 32'({ret_reg_we, ret_store_we}), 32'd0);
        check("R4", "lk_hit_nonhead", 32'(lk_hit), 32'd1);

        // R11 full buffer retires head while a new issue waits
        idle_inputs(); wb_valid = 1; wb_tag = 0; wb_value = 32'h0000_aaaa;
        step();
        idle_inputs(); iss_valid = 1; iss_class = 2'b01; iss_dest = 16'h0bee;
        step();

        // drain everything
        for (int k = 0; k < 40; k++) begin
            idle_inputs();
            for (int i = 0; i < DEPTH; i++) if (mv[i] && !mr[i]) begin
                wb_valid = 1; wb_tag = 3'(i); wb_value = 32'(32'hc000 + i);
            end
            step();
        end
        #1 check("R5", "drained", 32'(empty), 32'd1);

        // R3 writeback to a dead tag is ignored
        idle_inputs(); wb_valid = 1; wb_tag = 5; wb_value = 32'h5555; lk_tag = 5;
        step();
        #1 check("R3", "dead_wb_ignored", 32'(lk_hit), 32'd0);

        // R8 / R10 mispredicted branch at head with an issue pending
        idle_inputs(); iss_valid = 1; iss_class = 2'b10; step();
        idle_inputs(); iss_valid = 1; iss_class = 2'b00; iss_dest = 16'h7; step();
        idle_inputs(); wb_valid = 1; wb_tag = 3'(mt == 0 ? DEPTH - 1 : mt - 1); wb_value = 32'h77; step();
        idle_inputs(); wb_valid = 1; wb_tag = 3'((mt + DEPTH - 2) % DEPTH); wb_mispred = 1; step();
        idle_inputs(); iss_valid = 1; iss_dest = 16'h99;
        #1 check("R10", "flush_cycle_ready", 32'(iss_ready), 32'd0);
        check("R8", "flush_seen", 32'(ret_flush), 32'd1);
        step();
        #1 check("R8", "empty_after_flush", 32'(occupancy), 32'd0);
        check("R8", "tail_zero", 32'(iss_tag), 32'd0);

        // R9 exception on a store
        idle_inputs(); iss_valid = 1; iss_class = 2'b01; iss_dest = 16'h40; step();
        idle_inputs(); wb_valid = 1; wb_tag = 0; wb_exc = 1; wb_value = 32'h1; step();
        #1 check("R9", "exc_signal", 32'(ret_exc), 32'd1);
        check("R9", "exc_no_store", 32'(ret_store_we), 32'd0);
        idle_inputs(); step();

        // mixed random traffic
        for (int n = 0; n < 4000; n++) rand_cycle();

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule